// File: doc/BRIEF.md
# Multi-Mode Histogram Memory Engine

The engine holds a 1024-word by 24-bit store behind one clocked read-modify-write datapath. A latched 3-bit function code reuses that datapath for several jobs. It can count how often each 10-bit pixel value occurs. It can add a 24-bit weight into the bin that a pixel value selects. It can load and read back a lookup table. It can also act as a fixed 1024-sample delay line, or as a delay line that subtracts the current sample from the delayed one.

Each operation is sampled on a clock edge, looks up its word one cycle later, and writes the word back and registers its result on the edge after that. When two updates to the same bin arrive in consecutive cycles, the second one takes the first one's result from a one-entry bypass. No count is lost this way. A pause input (`run_n` high) stops counting, weighting and table loading. In the paused state the same pixel port reads bins out without changing them. An active-low flash clear empties the whole store in one cycle.

Top module: `hist_engine`

## Requirements
- R1: The function code is taken from `fcode` when `fload` rises (high at an edge after being low at the previous edge), and only if `run_n` is high at that edge. A rising `fload` while `run_n` is low leaves the mode unchanged. The codes are: 3'b000 counting, 3'b001 counting (second code), 3'b010 delay-and-subtract, 3'b011 table, 3'b100 weighted bins, 3'b101 delay line, 3'b110 and 3'b111 host-reserved.
- R2: In a counting mode with `run_n` low, each edge adds one, modulo 2^24, to the word at `pix`. Hits on the same bin in back-to-back cycles are all counted. The new count appears on `dout` after the second following edge.
- R3: In weighted-bin mode with `run_n` low, `din` is added modulo 2^24 to the word at `pix`, and the new sum appears on `dout` after the second following edge.
- R4: In table mode with `run_n` low, `din` is written to the word at `pix` and is shown on `dout` after the second following edge.
- R5: In the counting, weighted-bin and table modes, with `run_n` high, nothing is written. `dout` shows the word at `pix` after the second following edge.
- R6: In delay-line mode, independent of `run_n`, every edge stores `din` and puts the sample taken 1024 edges earlier on `dout` (after the second following edge). The sweep position is kept across mode changes.
- R7: In delay-and-subtract mode, independent of `run_n`, `dout` is the 1024-edge-old sample minus the current `din`, modulo 2^24. `din` is stored exactly as in R6.
- R8: `fclr_n` low at an edge zeroes every word, the sweep position and the pipeline, including operations sampled at the two preceding edges. Later reads return 0.
- R9: While `oe_n` is high, `dout` is all zero and `dout_vld` is low. While `oe_n` is low, `dout` carries the registered result and `dout_vld` is high.
- R10: In the host-reserved codes no word changes and the registered result is zero.
- R11: Synchronous active-high `rst` selects mode 3'b000, empties the store and zeroes the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fclr_n | input | 1 | Flash clear, active low |
| run_n | input | 1 | Pause when high; also gates mode loading |
| fload | input | 1 | Function load strobe, rising edge detected |
| fcode | input | 3 | Function code |
| pix | input | 10 | Pixel value / bin address |
| din | input | 24 | Weight, table word or delay sample |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 24 | Registered result, zero when disabled |
| dout_vld | output | 1 | High while `dout` is enabled |

## Verification
A result always depends on the inputs sampled at one edge and appears on `dout` after the second edge that follows. In the delay modes, a stored sample returns 1024 sampled edges after it was written, and that return is again seen two edges later. The bench keeps a cycle count and models every sampled edge in order. For each result it queues an item due three cycles after the falling edge on which it drove the stimulus. A monitor compares each item on the falling edge of that due cycle, so it never reads on an active edge. Flash clear and the output-enable check run only after the queue has drained, so no pending item depends on those events.

// File: rtl/hist_pkg.sv
package hist_pkg;

    localparam int unsigned HP_AW    = 10;
    localparam int unsigned HP_DW    = 24;
    localparam int unsigned HP_DEPTH = 1 << HP_AW;
    localparam logic [HP_DW-1:0] HP_ONE = HP_DW'(1);

    typedef enum logic [2:0] {
        FN_HIST   = 3'b000,
        FN_HACC   = 3'b001,
        FN_DSUB   = 3'b010,
        FN_LUT    = 3'b011,
        FN_BACC   = 3'b100,
        FN_DELAY  = 3'b101,
        FN_HOST24 = 3'b110,
        FN_HOST16 = 3'b111
    } fn_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_READ = 3'd1,
        OP_INC  = 3'd2,
        OP_ADD  = 3'd3,
        OP_LOAD = 3'd4,
        OP_DLY  = 3'd5,
        OP_DSUB = 3'd6
    } op_e;

    typedef struct packed {
        op_e              kind;
        logic [HP_AW-1:0] addr;
        logic [HP_DW-1:0] data;
    } op_t;

    typedef struct packed {
        logic             en;
        logic [HP_AW-1:0] addr;
        logic [HP_DW-1:0] data;
    } wr_t;

    function automatic op_e pick_op(fn_e fn, logic paused);
        case (fn)
            FN_HIST, FN_HACC: return paused ? OP_READ : OP_INC;
            FN_BACC:          return paused ? OP_READ : OP_ADD;
            FN_LUT:           return paused ? OP_READ : OP_LOAD;
            FN_DELAY:         return OP_DLY;
            FN_DSUB:          return OP_DSUB;
            default:          return OP_NONE;
        endcase
    endfunction

    function automatic logic is_sweep(fn_e fn);
        return (fn == FN_DELAY) || (fn == FN_DSUB);
    endfunction

    function automatic logic does_write(op_e k);
        return (k == OP_INC) || (k == OP_ADD) || (k == OP_LOAD) ||
               (k == OP_DLY) || (k == OP_DSUB);
    endfunction

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
    import hist_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run_n,
    input  logic             fload,
    input  logic [2:0]       fcode,
    input  logic [HP_AW-1:0] pix,
    input  logic [HP_DW-1:0] din,
    output op_t              issue
);

    fn_e              mode_q;
    logic             ld_q;
    logic [HP_AW-1:0] cnt_q;
    op_t              s1_q;
    logic             ld_rise;

    assign ld_rise = fload && !ld_q;
    assign issue   = s1_q;

    // mode register and load-strobe edge detector
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= FN_HIST;
            ld_q   <= 1'b0;
        end else begin
            ld_q <= fload;
            if (ld_rise && run_n)
                mode_q <= fn_e'(fcode);
        end
    end

    // sweep counter and first pipeline stage
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            s1_q  <= '0;
        end else begin
            s1_q.kind <= pick_op(mode_q, run_n);
            s1_q.addr <= is_sweep(mode_q) ? cnt_q : pix;
            s1_q.data <= din;
            if (is_sweep(mode_q))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: mode frozen while running
    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (rst)
        !run_n |=> $stable(mode_q));

    // R1: paused rising strobe takes the code
    p_mode_load_r1: assert property (@(posedge clk) disable iff (rst)
        (ld_rise && run_n) |=> (mode_q == fn_e'($past(fcode))));

    // R6: sweep advances by one in the delay modes
    p_sweep_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && is_sweep(mode_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/hist_mem.sv
module hist_mem
    import hist_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [HP_AW-1:0] rd_addr,
    input  logic             we,
    input  logic [HP_AW-1:0] wr_addr,
    input  logic [HP_DW-1:0] wr_data,
    output logic [HP_DW-1:0] rd_data
);

    logic [HP_DW-1:0]    word_q [HP_DEPTH];
    logic [HP_DEPTH-1:0] live_q;

    // word storage carries no reset; the live bits decide what it reads as
    always_ff @(posedge clk) begin
        if (we)
            word_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            live_q <= '0;
        else if (we)
            live_q[wr_addr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            rd_data <= '0;
        else
            rd_data <= live_q[rd_addr] ? word_q[rd_addr] : '0;
    end

    // R8: a flash clear empties the read register on the next cycle
    p_clear_read_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rd_data == '0));

endmodule

// File: rtl/hist_alu.sv
module hist_alu
    import hist_pkg::*;
(
    input  op_t              cur,
    input  logic [HP_DW-1:0] rd_data,
    input  wr_t              fwd,
    output wr_t              wr,
    output logic [HP_DW-1:0] res
);

    logic             hit;
    logic [HP_DW-1:0] old;

    always_comb begin
        hit     = fwd.en && (fwd.addr == cur.addr);
        old     = hit ? fwd.data : rd_data;
        wr.en   = does_write(cur.kind);
        wr.addr = cur.addr;
        wr.data = old;
        res     = '0;
        case (cur.kind)
            OP_READ: res = old;
            OP_INC: begin
                wr.data = old + HP_ONE;
                res     = old + HP_ONE;
            end
            OP_ADD: begin
                wr.data = old + cur.data;
                res     = old + cur.data;
            end
            OP_LOAD: begin
                wr.data = cur.data;
                res     = cur.data;
            end
            OP_DLY: begin
                wr.data = cur.data;
                res     = old;
            end
            OP_DSUB: begin
                wr.data = cur.data;
                res     = old - cur.data;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/hist_engine.sv
module hist_engine
    import hist_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fclr_n,
    input  logic             run_n,
    input  logic             fload,
    input  logic [2:0]       fcode,
    input  logic [HP_AW-1:0] pix,
    input  logic [HP_DW-1:0] din,
    input  logic             oe_n,
    output logic [HP_DW-1:0] dout,
    output logic             dout_vld
);

    logic             clr;
    op_t              s1;
    op_t              s2_q;
    wr_t              wb_q;
    wr_t              alu_wr;
    logic [HP_DW-1:0] alu_res;
    logic [HP_DW-1:0] rd_data;
    logic [HP_DW-1:0] dout_q;
    logic             mem_we;

    assign clr    = !fclr_n;
    assign mem_we = alu_wr.en && !clr && !rst;

    hist_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .run_n (run_n),
        .fload (fload),
        .fcode (fcode),
        .pix   (pix),
        .din   (din),
        .issue (s1)
    );

    hist_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .rd_addr (s1.addr),
        .we      (mem_we),
        .wr_addr (alu_wr.addr),
        .wr_data (alu_wr.data),
        .rd_data (rd_data)
    );

    hist_alu u_alu (
        .cur     (s2_q),
        .rd_data (rd_data),
        .fwd     (wb_q),
        .wr      (alu_wr),
        .res     (alu_res)
    );

    // second stage, write-back bypass and result register
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            s2_q   <= '0;
            wb_q   <= '0;
            dout_q <= '0;
        end else begin
            s2_q   <= s1;
            wb_q   <= alu_wr;
            dout_q <= alu_res;
        end
    end

    assign dout     = oe_n ? '0 : dout_q;
    assign dout_vld = !oe_n;

    // R2: an increment lands in the bypass and on the result together
    p_update_seen_r2: assert property (@(posedge clk) disable iff (rst)
        (s2_q.kind == OP_INC && !clr) |=> (wb_q.en && dout_q == wb_q.data));

    // R2: back-to-back hit on one bin builds on the previous write
    p_back2back_r2: assert property (@(posedge clk) disable iff (rst)
        (s2_q.kind == OP_INC && wb_q.en && wb_q.addr == s2_q.addr && !clr)
        |=> (wb_q.data == $past(wb_q.data) + HP_ONE));

    // R4: table load shows the loaded word
    p_lut_out_r4: assert property (@(posedge clk) disable iff (rst)
        (s2_q.kind == OP_LOAD && !clr) |=> (dout_q == $past(s2_q.data)));

    // R10: reserved codes never write
    p_host_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (s2_q.kind == OP_NONE) |=> !wb_q.en);

    // R8: flash clear zeroes the result register
    p_flash_out_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (dout_q == '0));

endmodule

// File: tb/sim_hist_engine.sv
module sim_hist_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        fclr_n;
    logic        run_n;
    logic        fload;
    logic [2:0]  fcode;
    logic [9:0]  pix;
    logic [23:0] din;
    logic        oe_n;
    logic [23:0] dout;
    logic        dout_vld;

    always #4 clk = ~clk;

    hist_engine u0 (
        .clk      (clk),
        .rst      (rst),
        .fclr_n   (fclr_n),
        .run_n    (run_n),
        .fload    (fload),
        .fcode    (fcode),
        .pix      (pix),
        .din      (din),
        .oe_n     (oe_n),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int unsigned cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned due;
        logic [23:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    item_t mon_it;

    // reference model state
    logic [23:0] ref_m [1024];
    logic [9:0]  ref_cnt;
    logic [2:0]  ref_mode;
    bit          ref_ld;

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    // monitor: compare queued items in their due cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            mon_it = sbq.pop_front();
            if (mon_it.due < cyc)
                check({mon_it.req, " (missed)"}, 24'hxxxxxx, mon_it.exp);
            else
                check(mon_it.req, dout, mon_it.exp);
        end
    end

    // driver: one sampled edge per call, modelled from the requirements
    task automatic step(input logic [9:0] p, input logic [23:0] d, input bit run,
                        input bit chk, input string req, input bit ld = 1'b0,
                        input logic [2:0] fc = 3'b000, input bit clr = 1'b0);
        logic [23:0] res;
        @(negedge clk);
        pix = p; din = d; run_n = !run; fload = ld; fcode = fc; fclr_n = !clr;
        res = '0;
        if (clr) begin
            for (int i = 0; i < 1024; i++) ref_m[i] = '0;
            ref_cnt = '0;
        end else begin
            case (ref_mode)
                3'b000, 3'b001: begin
                    if (run) ref_m[p] = ref_m[p] + 24'd1;
                    res = ref_m[p];
                end
                3'b100: begin
                    if (run) ref_m[p] = ref_m[p] + d;
                    res = ref_m[p];
                end
                3'b011: begin
                    if (run) ref_m[p] = d;
                    res = ref_m[p];
                end
                3'b101: begin
                    res = ref_m[ref_cnt];
                    ref_m[ref_cnt] = d;
                    ref_cnt = ref_cnt + 10'd1;
                end
                3'b010: begin
                    res = ref_m[ref_cnt] - d;
                    ref_m[ref_cnt] = d;
                    ref_cnt = ref_cnt + 10'd1;
                end
                default: res = '0;
            endcase
        end
        if (ld && !ref_ld && !run) ref_mode = fc;
        ref_ld = ld;
        if (chk && !clr) sbq.push_back('{cyc + 3, res, req});
    endtask

    task automatic set_mode(input logic [2:0] fc);
        step(10'd0, 24'd0, 1'b0, 1'b0, "", 1'b0, fc);
        step(10'd0, 24'd0, 1'b0, 1'b0, "", 1'b1, fc);
        step(10'd0, 24'd0, 1'b0, 1'b0, "", 1'b0, fc);
    endtask

    task automatic drain();
        while (sbq.size() > 0) step(10'd0, 24'd0, 1'b0, 1'b0, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [9:0] last;
        rst = 1'b1; fclr_n = 1'b1; run_n = 1'b1; fload = 1'b0;
        fcode = 3'b000; pix = '0; din = '0; oe_n = 1'b0;
        for (int i = 0; i < 1024; i++) ref_m[i] = '0;
        ref_cnt = '0; ref_mode = 3'b000; ref_ld = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11 dout after reset", dout, 24'd0);
        check("R11 dout_vld after reset", {23'd0, dout_vld}, 24'd1);
        for (int i = 0; i < 4; i++) step(10'(i), 24'd0, 1'b0, 1'b1, "R11 empty bin");

        // R2: counting in the default mode, with repeated bins
        last = '0;
        for (int i = 0; i < 300; i++) begin
            logic [9:0] pv;
            pv = ((i % 5) == 4) ? last : 10'($urandom_range(15, 0));
            step(pv, 24'($urandom), 1'b1, 1'b1, "R2 count");
            last = pv;
        end
        for (int i = 0; i < 6; i++) step(10'd7, 24'd0, 1'b1, 1'b1, "R2 burst");
        // R5: paused readout
        for (int i = 0; i < 16; i++) step(10'(i), 24'h123456, 1'b0, 1'b1, "R5 bin read");

        // R1: load while running is ignored; counting continues
        step(10'd3, 24'd0, 1'b1, 1'b1, "R1 load ignored", 1'b1, 3'b100);
        step(10'd3, 24'h000055, 1'b1, 1'b1, "R1 still counting", 1'b0, 3'b100);
        step(10'd3, 24'h000055, 1'b1, 1'b1, "R1 still counting", 1'b0, 3'b100);

        // R3: weighted bins with wrap
        set_mode(3'b100);
        step(10'd5, 24'hFFFFF0, 1'b1, 1'b1, "R3 add");
        step(10'd5, 24'h000020, 1'b1, 1'b1, "R3 wrap");
        for (int i = 0; i < 60; i++)
            step(10'($urandom_range(7, 0)), 24'($urandom), 1'b1, 1'b1, "R3 add");
        for (int i = 0; i < 8; i++) step(10'(i), 24'd9, 1'b0, 1'b1, "R5 sum read");

        // R4: table load and lookup
        set_mode(3'b011);
        for (int i = 100; i < 120; i++) step(10'(i), 24'($urandom), 1'b1, 1'b1, "R4 load");
        step(10'd110, 24'hABCDEF, 1'b1, 1'b1, "R4 reload");
        for (int i = 100; i < 120; i++) step(10'(i), 24'd0, 1'b0, 1'b1, "R4 lookup");

        // R10: reserved codes change nothing
        set_mode(3'b110);
        for (int i = 0; i < 20; i++)
            step(10'($urandom_range(1023, 0)), 24'($urandom), 1'b1, 1'b1, "R10 idle");
        set_mode(3'b111);
        for (int i = 0; i < 20; i++)
            step(10'(100 + i), 24'($urandom), 1'b1, 1'b1, "R10 idle");
        set_mode(3'b011);
        for (int i = 100; i < 120; i++) step(10'(i), 24'd0, 1'b0, 1'b1, "R10 table kept");

        // R6: delay line, run_n toggling
        set_mode(3'b101);
        for (int i = 0; i < 2100; i++)
            step(10'd0, 24'($urandom), bit'($urandom_range(1, 0)), 1'b1, "R6 delay");

        // R7: delay and subtract
        set_mode(3'b010);
        for (int i = 0; i < 1100; i++)
            step(10'd0, 24'($urandom), bit'($urandom_range(1, 0)), 1'b1, "R7 delsub");

        // R9: output enable
        set_mode(3'b011);
        drain();
        step(10'd110, 24'd0, 1'b0, 1'b0, "");
        step(10'd110, 24'd0, 1'b0, 1'b0, "");
        step(10'd110, 24'd0, 1'b0, 1'b0, "");
        @(negedge clk);
        oe_n = 1'b1; #1;
        check("R9 dout disabled", dout, 24'd0);
        check("R9 vld disabled", {23'd0, dout_vld}, 24'd0);
        oe_n = 1'b0; #1;
        check("R9 dout enabled", dout, ref_m[110]);
        check("R9 vld enabled", {23'd0, dout_vld}, 24'd1);

        // R8: flash clear after two paused reads
        step(10'd110, 24'd0, 1'b0, 1'b0, "");
        step(10'd110, 24'd0, 1'b0, 1'b0, "");
        step(10'd0, 24'd0, 1'b0, 1'b0, "", 1'b0, 3'b000, 1'b1);
        for (int i = 100; i < 106; i++) step(10'(i), 24'd0, 1'b0, 1'b1, "R8 cleared");
        set_mode(3'b101);
        for (int i = 0; i < 8; i++) step(10'd0, 24'h000777, 1'b1, 1'b1, "R8 sweep cleared");
        drain();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule